// File: doc/BRIEF.md
# Clock Frequency Configuration Controller

This block keeps the frequency and spread settings of a programmable clock synthesizer. Five strap pins (an input-reference select, a three-bit frequency code and a spread request) pass through a two-flop synchronizer. They are latched while reset is held, so the last values seen before reset is released become the strap settings. A control register then decides where the settings come from. In hardware mode they come from the latched straps. In software mode they come from register fields that firmware writes.

The selected reference and frequency code index a fixed table of PLL divider pairs. The table is computed from the target output frequency. A direct-programming mode bypasses the table and hands software-written M and N values to the PLL, where VCO = Fref x (N + 8) / (M + 2). The block also drives spread enable, spread type (down or center) and the reference-output enable. A separate status address always returns the live, synchronized pin levels.

Software reaches the registers through a plain internal write strobe with address and data, and a combinational read-data port.

Top module: `clkcfg_ctrl`

## Requirements
- R1: While reset is high the synchronized pins load both the strap latch and the soft select field. After release, address 0 reads bits 7..3 = {ref select, freq code[2:0], spread}, bit 2 (software mode) = 0, bit 1 = 0 and bit 0 (spread type) = 0.
- R2: With the 25 MHz reference selected (select bit = 0), the table gives M = 23 and N = round(F x 25 / 25 MHz) - 8. For codes 0..7 (100, 125, 133.33, 166.67, 200, 266, 333 and 400 MHz) this is N = 92, 117, 125, 159, 192, 258, 325 and 392.
- R3: With the 14.31818 MHz reference selected (select bit = 1), the table gives M = 19 and N = round(F x 21 / 14.31818 MHz) - 8. For codes 0..7 this is N = 139, 175, 188, 236, 285, 382, 480 and 579.
- R4: While address 0 bit 2 holds 0, a write to address 0 leaves bits 7..3 unchanged. Bit 2 and bit 0 are still written.
- R5: While bit 2 is 1, the reference select, frequency code and spread enable come from address 0 bits 7..3 and a write updates them. Clearing bit 2 returns every effective setting to the latched strap values.
- R6: Address 1 reads {ref select, freq code[2:0], spread} in bits 7..3 and zeros in bits 2..0. The value is taken from the live pins after two clock edges of synchronization, in either mode.
- R7: When address 2 bit 7 is 1, pll_m equals address 3 bits 5..0 and pll_n equals {address 3 bits 7..6, address 4 bits 7..0}. This holds whatever the frequency code.
- R8: After reset, address 2 reads 0x01: direct programming is off and the reference-output enable in bit 0 is on. Both outputs follow these bits.
- R9: pll_m, pll_n, ref_is_14m, spread_on, spread_center and refout_on are registered. Each changes on the first clock edge after the register state that drives it changes. spread_center follows address 0 bit 0 (0 = down-spread, 1 = center-spread).
- R10: In hardware mode, pin changes after reset do not reach the PLL settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; straps are captured while high |
| pin_ref_sel | input | 1 | Reference select strap (1 = 14.31818 MHz, 0 = 25 MHz) |
| pin_fsel | input | 3 | Frequency code strap |
| pin_spread | input | 1 | Spread request strap |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| pll_m | output | 6 | Effective M divider |
| pll_n | output | 10 | Effective N divider |
| ref_is_14m | output | 1 | Effective reference select |
| spread_on | output | 1 | Effective spread enable |
| spread_center | output | 1 | Spread type: 1 = center, 0 = down |
| refout_on | output | 1 | Reference output enable |

## Verification
The assertions check several behaviours on every cycle. Control writes made in hardware mode leave the soft select field untouched, and writes made in software mode take it. The pin status address trails the pins by exactly two edges. Direct M/N mode copies the programmed fields one edge later, and the spread type follows its bit one edge later. The directed scenarios cover the rest. They check the divider values of every table entry for both references, strap capture across reset, and the return to strap values when software mode is cleared. They also confirm that pin changes after reset leave the outputs alone, and they check the one-cycle output latency at the ports.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 3;
    localparam int M_W       = 6;
    localparam int N_W       = 10;
    localparam int FSEL_W    = 3;
    localparam int SEL_W     = FSEL_W + 1;
    localparam int ROM_DEPTH = 2 ** SEL_W;
    localparam int N_HI_W    = N_W - DATA_W;

    // fixed pre-dividers per reference (divisor = M + 2)
    localparam int M_REF14 = 19;
    localparam int M_REF25 = 23;
    // reference frequencies in kHz scaled by 22 to keep 14.31818 MHz exact
    localparam longint REF14_X22 = 315000;
    localparam longint REF25_X22 = 550000;

    // control register bit positions
    localparam int CTRL_SW_BIT   = 2;
    localparam int CTRL_TYPE_BIT = 0;
    localparam int AUX_MN_BIT    = 7;
    localparam int AUX_REFO_BIT  = 0;

    typedef struct packed {
        logic              ref14;
        logic [FSEL_W-1:0] fsel;
        logic              spread;
    } strap_t;

    localparam int STRAP_W = $bits(strap_t);
    localparam int STRAP_LSB = DATA_W - STRAP_W;

    typedef struct packed {
        logic [M_W-1:0] m;
        logic [N_W-1:0] n;
    } divs_t;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL = 3'd0,
        RA_PINS = 3'd1,
        RA_AUX  = 3'd2,
        RA_MNHI = 3'd3,
        RA_NLO  = 3'd4
    } reg_addr_e;

    function automatic longint code_khz(input logic [FSEL_W-1:0] code);
        case (code)
            3'd0:    return 100000;
            3'd1:    return 125000;
            3'd2:    return 133330;
            3'd3:    return 166670;
            3'd4:    return 200000;
            3'd5:    return 266000;
            3'd6:    return 333000;
            default: return 400000;
        endcase
    endfunction

    // rounded N for a target output frequency with a fixed M
    function automatic divs_t table_divs(input logic ref14, input logic [FSEL_W-1:0] code);
        divs_t  r;
        longint div;
        longint den;
        longint n8;
        div = ref14 ? longint'(M_REF14 + 2) : longint'(M_REF25 + 2);
        den = ref14 ? REF14_X22 : REF25_X22;
        n8  = (2 * code_khz(code) * div * 22 + den) / (2 * den);
        r.m = M_W'(div - 2);
        r.n = N_W'(n8 - 8);
        return r;
    endfunction

endpackage

// File: rtl/clkcfg_sync.sv
module clkcfg_sync #(
    parameter int WIDTH = 5
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    // free-running two-stage synchronizer; no reset so straps flow during reset
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk) begin
            s1 <= d[g];
            s2 <= s1;
        end
        assign q[g] = s2;
    end
endmodule

// File: rtl/clkcfg_regs.sv
module clkcfg_regs
    import clkcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  strap_t            pins_s,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output strap_t            strap_q,
    output strap_t            soft_q,
    output logic              sw_q,
    output logic              type_q,
    output logic              mn_en_q,
    output logic              refout_q,
    output divs_t             prog_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            strap_q  <= pins_s;
            soft_q   <= pins_s;
            sw_q     <= 1'b0;
            type_q   <= 1'b0;
            mn_en_q  <= 1'b0;
            refout_q <= 1'b1;
            prog_q   <= '0;
        end else if (we) begin
            case (reg_addr_e'(addr))
                RA_CTRL: begin
                    // select and spread fields only writable in software mode
                    if (sw_q) soft_q <= strap_t'(wdata[DATA_W-1:STRAP_LSB]);
                    sw_q   <= wdata[CTRL_SW_BIT];
                    type_q <= wdata[CTRL_TYPE_BIT];
                end
                RA_AUX: begin
                    mn_en_q  <= wdata[AUX_MN_BIT];
                    refout_q <= wdata[AUX_REFO_BIT];
                end
                RA_MNHI: begin
                    prog_q.n[N_W-1:DATA_W] <= wdata[DATA_W-1:DATA_W-N_HI_W];
                    prog_q.m               <= wdata[M_W-1:0];
                end
                RA_NLO: begin
                    prog_q.n[DATA_W-1:0] <= wdata;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (reg_addr_e'(addr))
            RA_CTRL: begin
                rdata[DATA_W-1:STRAP_LSB] = soft_q;
                rdata[CTRL_SW_BIT]        = sw_q;
                rdata[CTRL_TYPE_BIT]      = type_q;
            end
            RA_PINS: rdata[DATA_W-1:STRAP_LSB] = pins_s;
            RA_AUX: begin
                rdata[AUX_MN_BIT]   = mn_en_q;
                rdata[AUX_REFO_BIT] = refout_q;
            end
            RA_MNHI: rdata = {prog_q.n[N_W-1:DATA_W], prog_q.m};
            RA_NLO:  rdata = prog_q.n[DATA_W-1:0];
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/clkcfg_divsel.sv
module clkcfg_divsel
    import clkcfg_pkg::*;
(
    input  logic           clk,
    input  strap_t         strap_q,
    input  strap_t         soft_q,
    input  logic           sw_q,
    input  logic           type_q,
    input  logic           mn_en_q,
    input  logic           refout_q,
    input  divs_t          prog_q,
    output logic [M_W-1:0] pll_m,
    output logic [N_W-1:0] pll_n,
    output logic           ref_is_14m,
    output logic           spread_on,
    output logic           spread_center,
    output logic           refout_on
);
    divs_t            rom [ROM_DEPTH];
    strap_t           eff;
    logic [SEL_W-1:0] sel;
    divs_t            chosen;

    // divider table computed per entry from the target frequency
    for (genvar g = 0; g < ROM_DEPTH; g++) begin : g_rom
        localparam logic [SEL_W-1:0] IDX = SEL_W'(g);
        assign rom[g] = table_divs(IDX[SEL_W-1], IDX[FSEL_W-1:0]);
    end

    assign eff    = sw_q ? soft_q : strap_q;
    assign sel    = {eff.ref14, eff.fsel};
    assign chosen = mn_en_q ? prog_q : rom[sel];

    // output stage loads every cycle, so it settles from reset-time state
    always_ff @(posedge clk) begin
        pll_m         <= chosen.m;
        pll_n         <= chosen.n;
        ref_is_14m    <= eff.ref14;
        spread_on     <= eff.spread;
        spread_center <= type_q;
        refout_on     <= refout_q;
    end
endmodule

// File: rtl/clkcfg_ctrl.sv
module clkcfg_ctrl
    import clkcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_ref_sel,
    input  logic [FSEL_W-1:0] pin_fsel,
    input  logic              pin_spread,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [M_W-1:0]    pll_m,
    output logic [N_W-1:0]    pll_n,
    output logic              ref_is_14m,
    output logic              spread_on,
    output logic              spread_center,
    output logic              refout_on
);
    logic [STRAP_W-1:0] pins_raw;
    logic [STRAP_W-1:0] pins_sync;
    strap_t             pins_s;
    strap_t             strap_q;
    strap_t             soft_q;
    logic               sw_q;
    logic               type_q;
    logic               mn_en_q;
    logic               refout_q;
    divs_t              prog_q;

    assign pins_raw = {pin_ref_sel, pin_fsel, pin_spread};
    assign pins_s   = strap_t'(pins_sync);

    clkcfg_sync #(.WIDTH(STRAP_W)) i_sync (
        .clk (clk),
        .d   (pins_raw),
        .q   (pins_sync)
    );

    clkcfg_regs i_regs (
        .clk      (clk),
        .rst      (rst),
        .pins_s   (pins_s),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .strap_q  (strap_q),
        .soft_q   (soft_q),
        .sw_q     (sw_q),
        .type_q   (type_q),
        .mn_en_q  (mn_en_q),
        .refout_q (refout_q),
        .prog_q   (prog_q)
    );

    clkcfg_divsel i_divsel (
        .clk           (clk),
        .strap_q       (strap_q),
        .soft_q        (soft_q),
        .sw_q          (sw_q),
        .type_q        (type_q),
        .mn_en_q       (mn_en_q),
        .refout_q      (refout_q),
        .prog_q        (prog_q),
        .pll_m         (pll_m),
        .pll_n         (pll_n),
        .ref_is_14m    (ref_is_14m),
        .spread_on     (spread_on),
        .spread_center (spread_center),
        .refout_on     (refout_on)
    );
endmodule

// File: rtl/clkcfg_chk.sv
module clkcfg_chk
    import clkcfg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              pin_ref_sel,
    input logic [FSEL_W-1:0] pin_fsel,
    input logic              pin_spread,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input strap_t            soft_q,
    input logic              sw_q,
    input logic              type_q,
    input logic              mn_en_q,
    input divs_t             prog_q,
    input logic [M_W-1:0]    pll_m,
    input logic [N_W-1:0]    pll_n,
    input logic              spread_center
);
    logic [STRAP_W-1:0] pins_now;
    assign pins_now = {pin_ref_sel, pin_fsel, pin_spread};

    p_hw_write_ignored_r4: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == RA_CTRL && !sw_q) |=> $stable(soft_q));

    p_sw_write_taken_r5: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == RA_CTRL && sw_q) |=>
            (soft_q == strap_t'($past(reg_wdata[DATA_W-1:STRAP_LSB]))));

    p_pin_readback_r6: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == RA_PINS) |->
            (reg_rdata == {$past(pins_now, 2), {STRAP_LSB{1'b0}}}));

    p_mn_override_r7: assert property (@(posedge clk) disable iff (rst)
        $past(mn_en_q) |-> (pll_m == $past(prog_q.m) && pll_n == $past(prog_q.n)));

    p_spread_type_r9: assert property (@(posedge clk) disable iff (rst)
        spread_center == $past(type_q));
endmodule

bind clkcfg_ctrl clkcfg_chk i_chk (.*);

// File: tb/test_clkcfg_ctrl.sv
module test_clkcfg_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pin_ref_sel = 1'b0;
    logic [2:0] pin_fsel = 3'd0;
    logic       pin_spread = 1'b0;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic [5:0] pll_m;
    logic [9:0] pll_n;
    logic       ref_is_14m, spread_on, spread_center, refout_on;

    int checks = 0;
    int errors = 0;

    int n25 [8] = '{92, 117, 125, 159, 192, 258, 325, 392};
    int n14 [8] = '{139, 175, 188, 236, 285, 382, 480, 579};

    always #10 clk = ~clk;

    clkcfg_ctrl i_clkcfg_ctrl (
        .clk(clk), .rst(rst), .pin_ref_sel(pin_ref_sel), .pin_fsel(pin_fsel),
        .pin_spread(pin_spread), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pll_m(pll_m), .pll_n(pll_n),
        .ref_is_14m(ref_is_14m), .spread_on(spread_on),
        .spread_center(spread_center), .refout_on(refout_on)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic r, input logic [2:0] f, input logic s);
        @(negedge clk);
        pin_ref_sel = r; pin_fsel = f; pin_spread = s;
        rst = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        reg_addr = a;
        #1 v = int'(reg_rdata);
    endtask

    task automatic t_reset;
        int v;
        do_reset(1'b1, 3'd5, 1'b1);
        rd(3'd0, v);  chk("R1 ctrl after reset", v, 8'hD8);
        rd(3'd2, v);  chk("R8 aux after reset", v, 8'h01);
        chk("R8 refout_on", refout_on, 1);
        chk("R9 spread_center", spread_center, 0);
        chk("R1 strap spread_on", spread_on, 1);
        chk("R3 strap m", pll_m, 19);
        chk("R3 strap n", pll_n, n14[5]);
    endtask

    task automatic t_tables;
        do_reset(1'b0, 3'd0, 1'b0);
        wr(3'd0, 8'h04);
        for (int f = 0; f < 8; f++) begin
            wr(3'd0, {1'b0, 3'(f), 1'b0, 3'b100});
            @(negedge clk);
            chk("R2 m 25MHz", pll_m, 23);
            chk("R2 n 25MHz", pll_n, n25[f]);
            chk("R5 ref sel sw", ref_is_14m, 0);
        end
        for (int f = 0; f < 8; f++) begin
            wr(3'd0, {1'b1, 3'(f), 1'b1, 3'b100});
            @(negedge clk);
            chk("R3 m 14MHz", pll_m, 19);
            chk("R3 n 14MHz", pll_n, n14[f]);
            chk("R5 spread sw", spread_on, 1);
        end
    endtask

    task automatic t_hw_gate;
        int v;
        do_reset(1'b0, 3'd2, 1'b0);
        wr(3'd0, 8'hF9);
        rd(3'd0, v); chk("R4 hw write gated", v, 8'h21);
        chk("R9 not yet center", spread_center, 0);
        @(negedge clk);
        chk("R9 center after edge", spread_center, 1);
        chk("R4 n kept", pll_n, n25[2]);
        chk("R4 m kept", pll_m, 23);
    endtask

    task automatic t_sw_return;
        wr(3'd0, 8'h04);
        wr(3'd0, 8'h7C);
        @(negedge clk);
        chk("R5 sw n", pll_n, n25[7]);
        chk("R5 sw spread", spread_on, 1);
        wr(3'd0, 8'h78);
        @(negedge clk);
        chk("R5 back to strap n", pll_n, n25[2]);
        chk("R5 back to strap spread", spread_on, 0);
    endtask

    task automatic t_readback;
        int v;
        @(negedge clk);
        pin_ref_sel = 1'b1; pin_fsel = 3'd6; pin_spread = 1'b1;
        @(negedge clk);
        rd(3'd1, v); chk("R6 one edge still old", v, 8'h20);
        @(negedge clk);
        rd(3'd1, v); chk("R6 two edges new", v, 8'hE8);
        repeat (2) @(negedge clk);
        chk("R10 n unchanged", pll_n, n25[2]);
        chk("R10 ref unchanged", ref_is_14m, 0);
        chk("R10 spread unchanged", spread_on, 0);
    endtask

    task automatic t_mn;
        int v;
        wr(3'd3, 8'h85);
        wr(3'd4, 8'h33);
        rd(3'd3, v); chk("R7 mnhi readback", v, 8'h85);
        wr(3'd2, 8'h81);
        chk("R9 n before edge", pll_n, n25[2]);
        @(negedge clk);
        chk("R7 m override", pll_m, 5);
        chk("R7 n override", pll_n, 563);
        wr(3'd0, 8'h24);
        wr(3'd0, 8'hE4);
        @(negedge clk);
        chk("R7 n ignores code", pll_n, 563);
        wr(3'd2, 8'h00);
        @(negedge clk);
        chk("R8 refout off", refout_on, 0);
        chk("R7 table again", pll_n, n14[6]);
    endtask

    initial begin
        #(20 * 100000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_tables();
        t_hw_gate();
        t_sw_return();
        t_readback();
        t_mn();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule